// File: doc/BRIEF.md
# DMA Queue Run/Stop Controller

This block governs the run state of a single DMA hardware queue. Software reaches it through a small word-addressed register port. The port holds an enable bit, a pause bit, a self-clearing pointer-reset command, a read-only state field, the submission tail written by doorbells, and the completion head. The block decides when the external data mover may start fetching descriptors. It issues one fetch request per cycle while the queue runs, is not paused, has work between its fetch pointer and the tail, and the mover reports that it is not busy.

Stopping the queue takes two phases. First, software sets pause or clears enable. The queue then leaves the running state only once the mover's busy input is low, so in-flight work drains first, and it parks in a paused state. Second, while the queue is out of the running state, a reset command clears every pointer. When pause is released with enable clear, the queue returns to idle. Doorbell writes are always stored, but they only lead to fetches while the queue runs.

Top module: `qctl_queue_ctrl`

## Requirements
- R1: After the asynchronous reset, the state reads idle (0), enable and pause read 0, the tail, fetch and completion pointers are 0, and no fetch is requested.
- R2: In idle with enable=1 and pause=0, the state becomes run (1) in the cycle after the register write. In idle with pause=1, the queue stays idle even when enable=1.
- R3: In run with enable=1, pause=0, busy low and the fetch pointer unequal to the tail, fetch_req is high and fetch_idx equals the fetch pointer. The fetch pointer then advances by one each cycle, modulo 2^PTR_W.
- R4: A doorbell write at a time when the state is not run updates the tail, but no fetch request is made.
- R5: In run with pause=1 or enable=0, fetching stops at once. The state stays run while busy is high, and it moves to paused (2) on the first clock edge at which busy is low.
- R6: A reset command, written at a time when the state is not run, sets the tail, fetch and completion pointers to zero one cycle after the write. The reset command word always reads back as 0.
- R7: A reset command written while the state is run leaves all pointers and the state unchanged.
- R8: In paused with pause=0, the queue returns to run if enable=1 and goes to idle if enable=0. Run never moves directly to idle.
- R9: Register word offsets: 0 holds control (bit 0 enable, bit 1 pause); 1 holds the reset command (bit 0); 2 holds the read-only state in bits [1:0]; 3 holds the tail; 4 holds the completion head; 5 holds the read-only fetch pointer. Pointer writes keep only the low PTR_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read word offset |
| rd_data | output | DATA_W | Register read data (combinational) |
| mover_busy | input | 1 | Data mover has work in flight |
| fetch_req | output | 1 | Start one descriptor fetch this cycle |
| fetch_idx | output | PTR_W | Slot index of the requested fetch |
| q_state | output | 2 | Queue state: 0 idle, 1 run, 2 paused |
| sq_tail | output | PTR_W | Submission tail (doorbell) |
| sq_head | output | PTR_W | Fetch pointer |
| cq_head | output | PTR_W | Completion head |

## Verification
The bench holds busy high across a pause request. A controller that ignores in-flight work would report paused too early, and one that keeps fetching under pause would raise fetch_req once busy drops. It writes the reset command while running, where a controller that applies it anyway would zero the pointers under an active queue. It repeats the command while paused, where the pointers must clear. A doorbell that drives the fetch pointer across the ring end checks the wrap-around, because a bad modulo would lose slots or run past the tail. Further cases cover doorbells in idle, enable with pause held, and both ways out of paused, since a wrong state table would fetch from idle, start while paused, or skip a state.

// File: rtl/qctl_pkg.sv
package qctl_pkg;

  typedef enum logic [1:0] {
    Q_IDLE   = 2'd0,
    Q_RUN    = 2'd1,
    Q_PAUSED = 2'd2
  } qstate_e;

  // Register word offsets
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_RSTCMD = 1;
  localparam int unsigned OFS_STATE  = 2;
  localparam int unsigned OFS_TAIL   = 3;
  localparam int unsigned OFS_CQHEAD = 4;
  localparam int unsigned OFS_FETCH  = 5;

  // Bit positions inside control / command words
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_PAUSE = 1;
  localparam int unsigned BIT_RST   = 0;

endpackage

// File: rtl/qctl_regs.sv
module qctl_regs
  import qctl_pkg::*;
#(
  parameter int unsigned PTR_W  = 4,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ptr_clr,
  output logic              ctrl_en,
  output logic              ctrl_pause,
  output logic              rst_req,
  output logic [PTR_W-1:0]  tail_q,
  output logic [PTR_W-1:0]  cqh_q
);

  logic wr_ctrl, wr_rst, wr_tail, wr_cqh;
  logic wdata_unused;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
  assign wr_rst  = wr_en && (wr_addr == ADDR_W'(OFS_RSTCMD));
  assign wr_tail = wr_en && (wr_addr == ADDR_W'(OFS_TAIL));
  assign wr_cqh  = wr_en && (wr_addr == ADDR_W'(OFS_CQHEAD));
  assign wdata_unused = ^wr_data;

  // Next-state and enables
  logic             tail_ce, cqh_ce;
  logic [PTR_W-1:0] tail_d, cqh_d;
  logic             rst_req_d;

  always_comb begin
    tail_ce   = ptr_clr || wr_tail;
    tail_d    = ptr_clr ? '0 : wr_data[PTR_W-1:0];
    cqh_ce    = ptr_clr || wr_cqh;
    cqh_d     = ptr_clr ? '0 : wr_data[PTR_W-1:0];
    rst_req_d = wr_rst && wr_data[BIT_RST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      ctrl_pause <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_en    <= wr_data[BIT_EN];
      ctrl_pause <= wr_data[BIT_PAUSE];
    end
  end

  // Reset command is a one-cycle pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= rst_req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tail_q <= '0;
    else if (tail_ce) tail_q <= tail_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cqh_q <= '0;
    else if (cqh_ce) cqh_q <= cqh_d;
  end

endmodule

// File: rtl/qctl_fsm.sv
module qctl_fsm
  import qctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ctrl_en,
  input  logic    ctrl_pause,
  input  logic    mover_busy,
  input  logic    rst_req,
  output qstate_e state_q,
  output logic    ptr_clr,
  output logic    run_active
);

  qstate_e state_d;
  logic    stop_req;

  assign stop_req = ctrl_pause || !ctrl_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      Q_IDLE:   if (ctrl_en && !ctrl_pause) state_d = Q_RUN;
      Q_RUN:    if (stop_req && !mover_busy) state_d = Q_PAUSED;
      Q_PAUSED: if (!ctrl_pause) state_d = ctrl_en ? Q_RUN : Q_IDLE;
      default:  state_d = Q_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= Q_IDLE;
    else        state_q <= state_d;
  end

  // Pointers may only be cleared once the queue has left run
  assign ptr_clr    = rst_req && (state_q != Q_RUN);
  assign run_active = (state_q == Q_RUN) && !stop_req;

endmodule

// File: rtl/qctl_fetch.sv
module qctl_fetch #(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_active,
  input  logic             mover_busy,
  input  logic             ptr_clr,
  input  logic [PTR_W-1:0] tail_q,
  output logic             fetch_req,
  output logic [PTR_W-1:0] head_q
);

  logic             head_ce;
  logic [PTR_W-1:0] head_d;

  assign fetch_req = run_active && !mover_busy && (head_q != tail_q);

  always_comb begin
    head_ce = ptr_clr || fetch_req;
    head_d  = ptr_clr ? '0 : head_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       head_q <= '0;
    else if (head_ce) head_q <= head_d;
  end

endmodule

// File: rtl/qctl_rdmux.sv
module qctl_rdmux
  import qctl_pkg::*;
#(
  parameter int unsigned PTR_W  = 4,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ctrl_en,
  input  logic              ctrl_pause,
  input  qstate_e           state_q,
  input  logic [PTR_W-1:0]  tail_q,
  input  logic [PTR_W-1:0]  cqh_q,
  input  logic [PTR_W-1:0]  head_q,
  output logic [DATA_W-1:0] rd_data
);

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(OFS_CTRL)) begin
      rd_data[BIT_EN]    = ctrl_en;
      rd_data[BIT_PAUSE] = ctrl_pause;
    end else if (rd_addr == ADDR_W'(OFS_STATE)) begin
      rd_data[1:0] = state_q;
    end else if (rd_addr == ADDR_W'(OFS_TAIL)) begin
      rd_data[PTR_W-1:0] = tail_q;
    end else if (rd_addr == ADDR_W'(OFS_CQHEAD)) begin
      rd_data[PTR_W-1:0] = cqh_q;
    end else if (rd_addr == ADDR_W'(OFS_FETCH)) begin
      rd_data[PTR_W-1:0] = head_q;
    end
    // Reset command word and unmapped offsets read as zero
  end

endmodule

// File: rtl/qctl_queue_ctrl.sv
module qctl_queue_ctrl
  import qctl_pkg::*;
#(
  parameter int unsigned PTR_W  = 4,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              mover_busy,
  output logic              fetch_req,
  output logic [PTR_W-1:0]  fetch_idx,
  output logic [1:0]        q_state,
  output logic [PTR_W-1:0]  sq_tail,
  output logic [PTR_W-1:0]  sq_head,
  output logic [PTR_W-1:0]  cq_head
);

  logic    ctrl_en, ctrl_pause, rst_req, ptr_clr, run_active;
  qstate_e state_q;

  qctl_regs #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ptr_clr    (ptr_clr),
    .ctrl_en    (ctrl_en),
    .ctrl_pause (ctrl_pause),
    .rst_req    (rst_req),
    .tail_q     (sq_tail),
    .cqh_q      (cq_head)
  );

  qctl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_en    (ctrl_en),
    .ctrl_pause (ctrl_pause),
    .mover_busy (mover_busy),
    .rst_req    (rst_req),
    .state_q    (state_q),
    .ptr_clr    (ptr_clr),
    .run_active (run_active)
  );

  qctl_fetch #(.PTR_W(PTR_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_active (run_active),
    .mover_busy (mover_busy),
    .ptr_clr    (ptr_clr),
    .tail_q     (sq_tail),
    .fetch_req  (fetch_req),
    .head_q     (sq_head)
  );

  qctl_rdmux #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .rd_addr    (rd_addr),
    .ctrl_en    (ctrl_en),
    .ctrl_pause (ctrl_pause),
    .state_q    (state_q),
    .tail_q     (sq_tail),
    .cqh_q      (cq_head),
    .head_q     (sq_head),
    .rd_data    (rd_data)
  );

  assign fetch_idx = sq_head;
  assign q_state   = state_q;

endmodule

// File: rtl/qctl_queue_ctrl_chk.sv
module qctl_queue_ctrl_chk #(
  parameter int unsigned PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             mover_busy,
  input logic             fetch_req,
  input logic [1:0]       q_state,
  input logic [PTR_W-1:0] sq_tail,
  input logic [PTR_W-1:0] sq_head,
  input logic [PTR_W-1:0] cq_head
);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    q_state != 2'd3);  // R1

  AST_IDLE_NO_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (q_state == 2'd0) |=> (q_state != 2'd2));  // R2

  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> (sq_head == PTR_W'($past(sq_head) + 1'b1)));  // R3

  AST_NO_FETCH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (q_state == 2'd1));  // R4

  AST_BUSY_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (q_state == 2'd1 && mover_busy) |=> (q_state == 2'd1));  // R5

  AST_PTR_KEEP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (q_state == 2'd1 && !wr_en) |=> ($stable(sq_tail) && $stable(cq_head)));  // R7

  AST_RUN_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_state == 2'd1) |=> (q_state != 2'd0));  // R8

endmodule

bind qctl_queue_ctrl qctl_queue_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .mover_busy (mover_busy),
  .fetch_req  (fetch_req),
  .q_state    (q_state),
  .sq_tail    (sq_tail),
  .sq_head    (sq_head),
  .cq_head    (cq_head)
);

// File: tb/qctl_queue_ctrl_tb.sv
`timescale 1ns/1ps
module qctl_queue_ctrl_tb;

  localparam int PTR_W  = 4;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int RING   = 1 << PTR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              mover_busy;
  logic              fetch_req;
  logic [PTR_W-1:0]  fetch_idx;
  logic [1:0]        q_state;
  logic [PTR_W-1:0]  sq_tail, sq_head, cq_head;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  qctl_queue_ctrl #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mover_busy(mover_busy),
    .fetch_req(fetch_req), .fetch_idx(fetch_idx), .q_state(q_state),
    .sq_tail(sq_tail), .sq_head(sq_head), .cq_head(cq_head)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    #1;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = ADDR_W'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    int v;
    chk("R1 state", q_state, 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(2, v); chk("R1 state reg", v, 0);
    chk("R1 tail", sq_tail, 0);
    chk("R1 head", sq_head, 0);
    chk("R1 cq head", cq_head, 0);
    chk("R1 fetch", fetch_req, 0);
  endtask

  task automatic t_doorbell_idle();
    int v;
    wr(3, 'h1F5);
    chk("R9 tail masked", sq_tail, 5);
    rd(3, v); chk("R9 tail readback", v, 5);
    for (int i = 0; i < 3; i++) begin
      chk("R4 no fetch in idle", fetch_req, 0);
      step();
    end
    chk("R4 head unchanged", sq_head, 0);
    wr(4, 3);
    rd(4, v); chk("R9 cq head readback", v, 3);
    chk("R9 cq head port", cq_head, 3);
  endtask

  task automatic t_enable_fetch();
    int v;
    mover_busy = 1'b1;
    wr(0, 1);
    rd(0, v); chk("R9 ctrl readback", v, 1);
    chk("R2 not yet run", q_state, 0);
    step();
    chk("R2 run", q_state, 1);
    rd(2, v); chk("R9 state reg run", v, 1);
    chk("R3 busy blocks fetch", fetch_req, 0);
    mover_busy = 1'b0;
    #1;
    for (int i = 0; i < 5; i++) begin
      chk("R3 fetch req", fetch_req, 1);
      chk("R3 fetch idx", fetch_idx, i);
      step();
    end
    chk("R3 caught up", fetch_req, 0);
    chk("R3 head", sq_head, 5);
    rd(5, v); chk("R9 fetch ptr readback", v, 5);
    wr(3, 2);
    for (int i = 0; i < 13; i++) begin
      chk("R3 wrap req", fetch_req, 1);
      chk("R3 wrap idx", fetch_idx, (5 + i) % RING);
      step();
    end
    chk("R3 wrap done", fetch_req, 0);
    chk("R3 wrap head", sq_head, 2);
  endtask

  task automatic t_reset_in_run();
    int v;
    wr(1, 1);
    step();
    chk("R7 tail kept", sq_tail, 2);
    chk("R7 head kept", sq_head, 2);
    chk("R7 cq head kept", cq_head, 3);
    chk("R7 state kept", q_state, 1);
    rd(1, v); chk("R6 command reads 0", v, 0);
  endtask

  task automatic t_pause_drain();
    int v;
    @(negedge clk);
    mover_busy = 1'b1;
    wr(3, 6);
    wr(0, 2);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R5 busy holds run", q_state, 1);
      chk("R5 no fetch", fetch_req, 0);
    end
    mover_busy = 1'b0;
    #1;
    chk("R5 pause blocks fetch", fetch_req, 0);
    chk("R5 still run", q_state, 1);
    step();
    chk("R5 paused", q_state, 2);
    chk("R5 head frozen", sq_head, 2);
    rd(2, v); chk("R9 state reg paused", v, 2);
  endtask

  task automatic t_reset_paused();
    wr(1, 1);
    step();
    chk("R6 tail cleared", sq_tail, 0);
    chk("R6 head cleared", sq_head, 0);
    chk("R6 cq head cleared", cq_head, 0);
    chk("R6 stays paused", q_state, 2);
  endtask

  task automatic t_release();
    wr(0, 0);
    chk("R8 still paused", q_state, 2);
    step();
    chk("R8 paused to idle", q_state, 0);
  endtask

  task automatic t_enable_blocked();
    wr(0, 3);
    for (int i = 0; i < 2; i++) begin
      step();
      chk("R2 pause keeps idle", q_state, 0);
    end
    wr(0, 0);
  endtask

  task automatic t_resume();
    wr(3, 3);
    chk("R4 doorbell idle no fetch", fetch_req, 0);
    chk("R4 tail stored", sq_tail, 3);
    wr(0, 1);
    step();
    chk("R2 run again", q_state, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R3 refetch idx", fetch_idx, i);
      chk("R3 refetch req", fetch_req, 1);
      step();
    end
    chk("R3 refetch done", fetch_req, 0);
    wr(0, 3);
    step();
    chk("R5 pause leaves run", q_state, 2);
    wr(0, 1);
    step();
    chk("R8 paused to run", q_state, 1);
  endtask

  task automatic t_disable_only();
    wr(0, 0);
    step();
    chk("R5 disable leaves run", q_state, 2);
    step();
    chk("R8 then idle", q_state, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; mover_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_doorbell_idle();
    t_enable_fetch();
    t_reset_in_run();
    t_pause_drain();
    t_reset_paused();
    t_release();
    t_enable_blocked();
    t_resume();
    t_disable_only();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule